// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side command interpreter of a parallel NOR flash. It watches single-cycle write strobes carrying an address and a data word, and steps through the multi-write unlock scripts that switch the device into identification mode or query mode, or that start a chip erase or a sector erase. It never touches the storage array. Array data comes in on an input port and is passed through on ordinary reads.

The read path is one register. In identification mode it returns the manufacturer code or the device code, depending on the read address. In query mode it raises a flag so that an outside query table can answer, and it passes the array-side input through unchanged. While an erase runs, it returns a status word whose two toggle bits invert on every read, and the ready output is held low for a parameterised number of clock cycles. Writes that arrive during an erase are discarded.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `busy_n` is 1 and `cfi_mode`, `erase_go` and `rd_data` are 0. Reads return `array_data`.
- R2: The writes 555h/AAh, then 2AAh/55h, then 555h/90h enter identification mode. In that mode a read whose low 11 address bits are 0 returns 00BFh. If they are 1, the read returns the device code: 233Bh, or 233Ah when `ALT_ID` is 1. Any other address returns 0000h.
- R3: The same script ending in 555h/98h enters query mode. In query mode `cfi_mode` is 1 and reads return `array_data`.
- R4: Only address bits [10:0] and data bits [7:0] take part in command matching. Address bits above 10 and data bits [15:8] have no effect.
- R5: A write that is not the next expected step returns the decoder to its first step. That write does not count as the first step of a new script.
- R6: A write with data byte F0h at any address, including as the third write after 555h/AAh and 2AAh/55h, returns the decoder to array-read mode with `cfi_mode` at 0.
- R7: The five writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h followed by 555h/10h start a chip erase. `erase_go` pulses for one cycle with `erase_chip` at 1, and `busy_n` is 0 for exactly `ERASE_CYCLES` cycles.
- R8: The same five-write prefix followed by data 50h at any address starts a sector erase. `erase_go` pulses with `erase_chip` at 0, and `erase_addr` holds that full address.
- R9: While `busy_n` is 0, each read returns a word that is 0 except bits 6 and 2. Those two bits are equal, and they are inverted from the previous busy read. After the erase, repeated reads of unchanged array data are stable.
- R10: Writes received while `busy_n` is 0 are ignored. They cause no mode change, no script progress and no `erase_go`. After an erase the decoder is in array-read mode.
- R11: `rd_data` updates one cycle after a read strobe and holds between reads. A read in the same cycle as a mode-changing write is answered in the mode that applied before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 16 | Data from the array or query table |
| rd_data | output | 16 | Registered read response |
| busy_n | output | 1 | Low while an erase runs |
| cfi_mode | output | 1 | High in query mode |
| erase_go | output | 1 | One-cycle erase start pulse |
| erase_chip | output | 1 | 1 for chip erase, 0 for sector erase |
| erase_addr | output | ADDR_W | Address of the erase-starting write |

## Verification
Two functions can land in one clock edge: a write that completes a script, and a read strobe. The bench raises both strobes in the same cycle, with the final 90h write and a read of address 0. It expects the array value back rather than the manufacturer code, and then expects 00BFh on the next read. A second same-cycle case lies at the edge of an erase. Reads and full scripts issued during the busy window must leave the mode untouched, and the toggle bits must alternate right up to the cycle where `busy_n` returns high.

// File: rtl/flash_cmd_pkg.sv
// Shared constants and types for the flash command decoder.
// Assumes the command match width is 11 address bits and 8 data bits.
package flash_cmd_pkg;
    localparam int CMP_AW = 11;
    localparam int CMP_DW = 8;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_ID    = 2'd1,
        MODE_CFI   = 2'd2
    } rd_mode_e;

    localparam logic [CMP_AW-1:0] ADR_KEY_A = 11'h555;
    localparam logic [CMP_AW-1:0] ADR_KEY_B = 11'h2AA;

    localparam logic [CMP_DW-1:0] DAT_KEY_A  = 8'hAA;
    localparam logic [CMP_DW-1:0] DAT_KEY_B  = 8'h55;
    localparam logic [CMP_DW-1:0] DAT_IDENT  = 8'h90;
    localparam logic [CMP_DW-1:0] DAT_QUERY  = 8'h98;
    localparam logic [CMP_DW-1:0] DAT_ERSPRE = 8'h80;
    localparam logic [CMP_DW-1:0] DAT_CHIP   = 8'h10;
    localparam logic [CMP_DW-1:0] DAT_SECT   = 8'h50;
    localparam logic [CMP_DW-1:0] DAT_LEAVE  = 8'hF0;

    localparam logic [15:0] MFR_CODE  = 16'h00BF;
    localparam logic [15:0] TOGL_MASK = 16'h0044;
endpackage

// File: rtl/cmd_seq_tracker.sv
// Tracks progress through the unlock scripts and holds the read mode.
// Assumes one-cycle write strobes; writes while busy_i is high are dropped.
// start_o is combinational so the erase timer loads on the same edge.
module cmd_seq_tracker
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              busy_i,
    output rd_mode_e          mode_o,
    output logic              start_o,
    output logic              erase_go_o,
    output logic              erase_chip_o,
    output logic [ADDR_W-1:0] erase_addr_o
);
    localparam int STEP_W = 3;

    logic [STEP_W-1:0] step_q, step_d;
    rd_mode_e          mode_q, mode_d;
    logic              chip_c;
    logic              go_q, chip_q;
    logic [ADDR_W-1:0] addr_q;

    logic [CMP_DW-1:0] dbyte;
    logic              at_a, at_b;
    logic              unused_hi_data;

    assign dbyte          = wr_data[CMP_DW-1:0];
    assign at_a           = (wr_addr[CMP_AW-1:0] == ADR_KEY_A);
    assign at_b           = (wr_addr[CMP_AW-1:0] == ADR_KEY_B);
    assign unused_hi_data = ^wr_data[15:CMP_DW];

    // Next step, next mode and erase start for the current write.
    always_comb begin
        step_d  = step_q;
        mode_d  = mode_q;
        start_o = 1'b0;
        chip_c  = 1'b0;
        if (wr_en && !busy_i) begin
            step_d = '0;
            if (dbyte == DAT_LEAVE) begin
                mode_d = MODE_ARRAY;
            end else begin
                case (step_q)
                    3'd0: if (at_a && dbyte == DAT_KEY_A) step_d = 3'd1;
                    3'd1: if (at_b && dbyte == DAT_KEY_B) step_d = 3'd2;
                    3'd2: if (at_a) begin
                        if (dbyte == DAT_IDENT)       mode_d = MODE_ID;
                        else if (dbyte == DAT_QUERY)  mode_d = MODE_CFI;
                        else if (dbyte == DAT_ERSPRE) step_d = 3'd3;
                    end
                    3'd3: if (at_a && dbyte == DAT_KEY_A) step_d = 3'd4;
                    3'd4: if (at_b && dbyte == DAT_KEY_B) step_d = 3'd5;
                    3'd5: begin
                        if (at_a && dbyte == DAT_CHIP) begin
                            start_o = 1'b1;
                            chip_c  = 1'b1;
                        end else if (dbyte == DAT_SECT) begin
                            start_o = 1'b1;
                        end
                    end
                    default: step_d = '0;
                endcase
            end
            if (start_o) mode_d = MODE_ARRAY;
        end
    end

    // Registers for script progress, mode and the erase request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            mode_q <= MODE_ARRAY;
            go_q   <= 1'b0;
            chip_q <= 1'b0;
            addr_q <= '0;
        end else begin
            step_q <= step_d;
            mode_q <= mode_d;
            go_q   <= start_o;
            if (start_o) begin
                chip_q <= chip_c;
                addr_q <= wr_addr;
            end
        end
    end

    assign mode_o       = mode_q;
    assign erase_go_o   = go_q;
    assign erase_chip_o = chip_q;
    assign erase_addr_o = addr_q;

    // Busy writes leave mode and script progress untouched.
    assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && wr_en) |=> ($stable(mode_q) && $stable(step_q)));

    // An erase request only follows a completed five-write prefix.
    assert_go_after_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> ($past(step_q) == 3'd5));

    // The erase request is a single-cycle pulse.
    assert_go_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |=> !go_q);
endmodule

// File: rtl/erase_timer.sv
// Counts the simulated erase duration and reports busy.
// Assumes start_i never arrives while busy (the tracker gates it).
module erase_timer #(
    parameter int ERASE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int              CNT_W = $clog2(ERASE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD  = CNT_W'(ERASE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (start_i)     cnt_q <= LOAD;
        else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy_o = (cnt_q != '0);

    assert_busy_follows_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    assert_no_restart_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
endmodule

// File: rtl/read_responder.sv
// Registered read path: array data, identifier codes or toggle status.
// Assumes one-cycle read strobes; identifier decode uses address bits [10:0].
module read_responder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter bit ALT_ID = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       array_data,
    input  rd_mode_e          mode_i,
    input  logic              busy_i,
    output logic [15:0]       rd_data_o
);
    localparam logic [15:0] DEV_CODE = ALT_ID ? 16'h233A : 16'h233B;

    logic [15:0]       rd_q, rd_d;
    logic              tog_q;
    logic [CMP_AW-1:0] low_addr;
    logic              unused_hi_addr;

    assign low_addr       = rd_addr[CMP_AW-1:0];
    assign unused_hi_addr = ^rd_addr[ADDR_W-1:CMP_AW];

    // Select the response for a read in the current mode.
    always_comb begin
        if (busy_i) begin
            rd_d = TOGL_MASK & {16{~tog_q}};
        end else if (mode_i == MODE_ID) begin
            if (low_addr == '0)                   rd_d = MFR_CODE;
            else if (low_addr == CMP_AW'(1))      rd_d = DEV_CODE;
            else                                  rd_d = '0;
        end else begin
            rd_d = array_data;
        end
    end

    // Capture the response and advance the toggle on busy reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            tog_q <= 1'b0;
        end else if (rd_en) begin
            rd_q <= rd_d;
            if (busy_i) tog_q <= ~tog_q;
        end
    end

    assign rd_data_o = rd_q;

    assert_status_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy_i) |=> (((rd_q & ~TOGL_MASK) == 16'h0) && (rd_q[6] == rd_q[2])));

    assert_read_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder: script tracker, erase timer, read path.
// Assumes ADDR_W is greater than 11 and strobes are one cycle wide.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 18,
    parameter int ERASE_CYCLES = 1000,
    parameter bit ALT_ID       = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       array_data,
    output logic [15:0]       rd_data,
    output logic              busy_n,
    output logic              cfi_mode,
    output logic              erase_go,
    output logic              erase_chip,
    output logic [ADDR_W-1:0] erase_addr
);
    rd_mode_e mode;
    logic     start;
    logic     busy;

    cmd_seq_tracker #(.ADDR_W(ADDR_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .busy_i       (busy),
        .mode_o       (mode),
        .start_o      (start),
        .erase_go_o   (erase_go),
        .erase_chip_o (erase_chip),
        .erase_addr_o (erase_addr)
    );

    erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy)
    );

    read_responder #(.ADDR_W(ADDR_W), .ALT_ID(ALT_ID)) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .array_data (array_data),
        .mode_i     (mode),
        .busy_i     (busy),
        .rd_data_o  (rd_data)
    );

    assign busy_n   = ~busy;
    assign cfi_mode = (mode == MODE_CFI);

    // The erase pulse and ready-low start on the same edge.
    assert_go_with_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> !busy_n);
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
    localparam int AW = 18;
    localparam int EC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   array_data = '0;
    logic [15:0]   rd_data;
    logic          busy_n, cfi_mode, erase_go, erase_chip;
    logic [AW-1:0] erase_addr;

    int total = 0;
    int bad = 0;
    int m_step = 0;
    int m_mode = 0;

    flash_cmd_decoder #(.ADDR_W(AW), .ERASE_CYCLES(EC), .ALT_ID(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .array_data(array_data), .rd_data(rd_data), .busy_n(busy_n),
        .cfi_mode(cfi_mode), .erase_go(erase_go), .erase_chip(erase_chip),
        .erase_addr(erase_addr)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [15:0] arr,
                      output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; array_data = arr;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    function automatic logic [AW-1:0] hi_rand(input logic [10:0] low);
        logic [AW-1:0] r;
        r = AW'($urandom);
        r[10:0] = low;
        return r;
    endfunction

    function automatic logic [15:0] exp_read(input int mode, input logic [AW-1:0] a,
                                             input logic [15:0] arr);
        if (mode == 1) begin
            if (a[10:0] == 11'h0) return 16'h00BF;
            if (a[10:0] == 11'h1) return 16'h233B;
            return 16'h0000;
        end
        return arr;
    endfunction

    // Reference script model following the requirements.
    task automatic model_wr(input logic [AW-1:0] a, input logic [15:0] d,
                            output bit start, output bit chip);
        logic [10:0] la;
        logic [7:0]  db;
        int ns;
        la = a[10:0]; db = d[7:0];
        start = 0; chip = 0; ns = 0;
        if (db == 8'hF0) m_mode = 0;
        else case (m_step)
            0: if (la == 11'h555 && db == 8'hAA) ns = 1;
            1: if (la == 11'h2AA && db == 8'h55) ns = 2;
            2: if (la == 11'h555) begin
                if (db == 8'h90) m_mode = 1;
                else if (db == 8'h98) m_mode = 2;
                else if (db == 8'h80) ns = 3;
            end
            3: if (la == 11'h555 && db == 8'hAA) ns = 4;
            4: if (la == 11'h2AA && db == 8'h55) ns = 5;
            5: begin
                if (la == 11'h555 && db == 8'h10) begin start = 1; chip = 1; end
                else if (db == 8'h50) start = 1;
            end
            default: ns = 0;
        endcase
        if (start) m_mode = 0;
        m_step = ns;
    endtask

    // Write through the model and check the erase outputs.
    task automatic do_wr(input logic [AW-1:0] a, input logic [15:0] d);
        bit st, ch;
        model_wr(a, d, st, ch);
        wr(a, d);
        chk(erase_go == st, "R5 erase_go after write", 32'(erase_go), 32'(st));
        if (st) begin
            chk(erase_chip == ch, ch ? "R7 chip kind" : "R8 sector kind",
                32'(erase_chip), 32'(ch));
            if (!ch) chk(erase_addr == a, "R8 erase_addr", 32'(erase_addr), 32'(a));
            while (!busy_n) @(negedge clk);
        end
    endtask

    task automatic prefix5();
        wr(18'h00555, 16'h00AA); wr(18'h002AA, 16'h0055); wr(18'h00555, 16'h0080);
        wr(18'h00555, 16'h00AA); wr(18'h002AA, 16'h0055);
    endtask

    initial begin
        #(10 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v, r1, r2, r3;
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy_n == 1'b1, "R1 busy_n", 32'(busy_n), 1);
        chk(cfi_mode == 1'b0 && erase_go == 1'b0, "R1 flags",
            32'({cfi_mode, erase_go}), 0);
        chk(rd_data == 16'h0, "R1 rd_data", 32'(rd_data), 0);
        rd(18'h0, 16'h1357, v);
        chk(v == 16'h1357, "R1 array read", 32'(v), 32'h1357);

        // R2 identification mode
        wr(18'h00555, 16'h00AA); wr(18'h002AA, 16'h0055); wr(18'h00555, 16'h0090);
        rd(18'h0, 16'h9999, v);
        chk(v == 16'h00BF, "R2 manufacturer", 32'(v), 32'h00BF);
        rd(18'h1, 16'h9999, v);
        chk(v == 16'h233B, "R2 device", 32'(v), 32'h233B);
        rd(18'h7, 16'h9999, v);
        chk(v == 16'h0000, "R2 other addr", 32'(v), 0);
        // R6 F0 at arbitrary address
        wr(18'h12345, 16'hABF0);
        rd(18'h0, 16'h2468, v);
        chk(v == 16'h2468, "R6 F0 exit", 32'(v), 32'h2468);

        // R3 query mode, R6 exit script
        wr(18'h00555, 16'h00AA); wr(18'h002AA, 16'h0055); wr(18'h00555, 16'h0098);
        chk(cfi_mode == 1'b1, "R3 cfi_mode", 32'(cfi_mode), 1);
        rd(18'h10, 16'h0051, v);
        chk(v == 16'h0051, "R3 passthrough", 32'(v), 32'h51);
        wr(18'h00555, 16'h00AA); wr(18'h002AA, 16'h0055); wr(18'h00555, 16'h00F0);
        chk(cfi_mode == 1'b0, "R6 exit script", 32'(cfi_mode), 0);

        // R4 upper bits ignored
        wr(18'h3F555, 16'h7EAA); wr(18'h20AAA, 16'hC355); wr(18'h1D555, 16'hFF90);
        rd(18'h20000, 16'h4444, v);
        chk(v == 16'h00BF, "R4 high bits ignored", 32'(v), 32'h00BF);
        wr(18'h0, 16'h00F0);

        // R5 broken script: stray repeat of first step
        wr(18'h00555, 16'h00AA); wr(18'h00555, 16'h00AA);
        wr(18'h002AA, 16'h0055); wr(18'h00555, 16'h0090);
        rd(18'h0, 16'h6161, v);
        chk(v == 16'h6161, "R5 mismatch to idle", 32'(v), 32'h6161);

        // R11 same-cycle write and read
        wr(18'h00555, 16'h00AA); wr(18'h002AA, 16'h0055);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 18'h00555; wr_data = 16'h0090;
        rd_en = 1'b1; rd_addr = 18'h0; array_data = 16'h1111;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk(rd_data == 16'h1111, "R11 old mode answers", 32'(rd_data), 32'h1111);
        @(negedge clk);
        chk(rd_data == 16'h1111, "R11 holds", 32'(rd_data), 32'h1111);
        rd(18'h0, 16'h1111, v);
        chk(v == 16'h00BF, "R11 new mode next read", 32'(v), 32'h00BF);
        wr(18'h0, 16'h00F0);

        // R7 chip erase duration
        prefix5();
        wr(18'h00555, 16'h0010);
        chk(erase_go == 1'b1 && erase_chip == 1'b1, "R7 chip go",
            32'({erase_go, erase_chip}), 3);
        n = 0;
        while (busy_n == 1'b0 && n < 1000) begin n++; @(negedge clk); end
        chk(n == EC, "R7 busy length", 32'(n), 32'(EC));

        // R8 sector erase, R9 toggling, R10 writes ignored while busy
        prefix5();
        wr(18'h12345, 16'h0050);
        chk(erase_go == 1'b1 && erase_chip == 1'b0, "R8 sector go",
            32'({erase_go, erase_chip}), 2);
        chk(erase_addr == 18'h12345, "R8 address", 32'(erase_addr), 32'h12345);
        rd(18'h0, 16'hFFFF, r1); rd(18'h0, 16'hFFFF, r2); rd(18'h0, 16'hFFFF, r3);
        chk((r1 & 16'hFFBB) == 0 && r1[6] == r1[2], "R9 status shape", 32'(r1), 32'h44);
        chk(r2 == (r1 ^ 16'h0044), "R9 toggle 1-2", 32'(r2), 32'(r1 ^ 16'h0044));
        chk(r3 == r1, "R9 toggle 2-3", 32'(r3), 32'(r1));
        wr(18'h00555, 16'h00AA); wr(18'h002AA, 16'h0055); wr(18'h00555, 16'h0090);
        chk(erase_go == 1'b0 && busy_n == 1'b0, "R10 no go while busy",
            32'({erase_go, busy_n}), 0);
        while (!busy_n) @(negedge clk);
        rd(18'h0, 16'hA5A5, r1); rd(18'h0, 16'hA5A5, r2);
        chk(r1 == 16'hA5A5, "R10 busy ID script ignored", 32'(r1), 32'hA5A5);
        chk(r2 == r1, "R9 stable after erase", 32'(r2), 32'(r1));

        // Random mix checked against the model
        m_step = 0; m_mode = 0;
        for (int i = 0; i < 300; i++) begin
            int k;
            logic [15:0] hd;
            logic [AW-1:0] ra;
            logic [15:0] arr;
            k  = $urandom_range(0, 9);
            hd = 16'($urandom) & 16'hFF00;
            case (k)
                0: do_wr(hi_rand(11'h555), hd | 16'h00AA);
                1: do_wr(hi_rand(11'h2AA), hd | 16'h0055);
                2: do_wr(hi_rand(11'h555), hd | 16'h0090);
                3: do_wr(hi_rand(11'h555), hd | 16'h0098);
                4: do_wr(hi_rand(11'h555), hd | 16'h0080);
                5: do_wr(AW'($urandom), hd | 16'h00F0);
                6: do_wr(hi_rand(11'h555), hd | 16'h0010);
                7: do_wr(AW'($urandom), hd | 16'h0050);
                8: do_wr(AW'($urandom), 16'($urandom));
                default: begin
                    do_wr(hi_rand(11'h555), hd | 16'h00AA);
                    do_wr(hi_rand(11'h2AA), hd | 16'h0055);
                    do_wr(hi_rand(11'h555), hd | 16'h0080);
                    do_wr(hi_rand(11'h555), hd | 16'h00AA);
                    do_wr(hi_rand(11'h2AA), hd | 16'h0055);
                end
            endcase
            ra  = hi_rand(11'($urandom_range(0, 2)));
            arr = 16'($urandom);
            rd(ra, arr, v);
            chk(v == exp_read(m_mode, ra, arr), "R4 random read", 32'(v),
                32'(exp_read(m_mode, ra, arr)));
            chk(cfi_mode == (m_mode == 2), "R3 random cfi_mode", 32'(cfi_mode),
                32'(m_mode == 2));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule